// File: doc/BRIEF.md
# Three-Level Page-Table Walker

When the translation cache cannot translate a virtual page number, this block looks up the translation in memory. It takes one miss request, which carries the virtual page number and the physical address of the top-level table. It then reads one 64-bit entry from each of three table levels in turn. The address of each read comes from the base of the current table plus a slice of the virtual page number, scaled by the 8-byte entry size. Level 1 starts from the root pointer. Levels 2 and 3 start from the frame held in the entry that the previous level returned.

Each walk ends in one of two ways, and the present bit of the entry just read decides which. If the third entry is present, the walker hands that entry to the translation cache for installation. After that install, the stalled access can complete using the new translation. If any entry is not present, the walk stops at once and the walker reports a page fault, giving the level at which the walk stopped. The walker serves one miss at a time. It has one read in flight at most, issued over a valid/ready request channel and answered by a valid-only response channel.

Top module: `pgwalk_top`

## Requirements
- R1: After synchronous reset the walker is idle. `miss_ready` is 1, and `mem_req_valid`, `done_valid` and `fault_valid` are all 0.
- R2: A walk starts on a clock edge where `miss_valid` and `miss_ready` are both 1. From the next cycle until the walk finishes, `miss_ready` is 0 and any `miss_valid` is ignored, so the reported `result_vpn` stays that of the walk that was accepted.
- R3: The first read address is the root pointer with its low 12 bits cleared, plus 8 times index field 1. Index field 1 is bits [26:18] of the VPN.
- R4: The second and third read addresses are the previous entry's bits [39:12] shifted left by 12, plus 8 times the index field for that level. The field for level 2 is VPN bits [17:9], and the field for level 3 is bits [8:0].
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` does not change.
- R6: A read is accepted on the edge where `mem_req_valid` and `mem_req_ready` are both 1. No new request is raised until a response arrives on `mem_rsp_valid`, so at most one read is outstanding.
- R7: If the level-3 entry has bit 0 (present) set, `done_valid` is 1 for exactly one cycle. During that cycle `done_pte` holds that entry and `result_vpn` holds the walked VPN. Exactly three reads were issued for the walk.
- R8: A response with bit 0 clear at level L ends the walk. `fault_valid` is 1 for exactly one cycle, and `fault_level` holds L, coded 0, 1 or 2 for levels 1, 2 and 3. No further read is issued.
- R9: One cycle after `done_valid` or `fault_valid`, the walker is idle again with `miss_ready` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| miss_vpn | input | VPN_W (27) | Virtual page number that missed |
| miss_root | input | ADDR_W (40) | Physical address of the level-1 table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W (40) | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W (64) | Entry read from memory |
| done_valid | output | 1 | Walk succeeded; install `done_pte` |
| done_pte | output | PTE_W (64) | Final-level entry |
| fault_valid | output | 1 | Walk ended in a page fault |
| fault_level | output | 2 | Level where a not-present entry was found |
| result_vpn | output | VPN_W (27) | VPN of the walk being reported |

## Verification
The sweep combines eight VPN patterns with four outcomes. The patterns include all-zero, all-one, one field saturated at a time, and mixed values, and each tells apart a swapped, shifted or truncated index field. The outcomes are a fault at level 1, 2 or 3, or a full install; together they separate an early stop from a read that was issued anyway, and a wrong fault-level code. Root pointers with nonzero low bits show whether the base is aligned. Varying delays on request acceptance and on the response show whether the request is held steady and whether only one read is in flight. A second miss raised during a walk shows whether a busy walker really ignores new requests.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTW_LEVELS      = 3;
    localparam int PTE_PRESENT_BIT = 0;
    localparam int PAGE_SHIFT      = 12;
    localparam int PTE_SIZE_LOG2   = 3;

    typedef logic [1:0] level_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_INSTALL,
        ST_FAULT
    } walk_state_e;

    function automatic level_t last_level();
        return level_t'(PTW_LEVELS - 1);
    endfunction

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import ptw_pkg::*;
#(
    parameter int VPN_W = 27,
    localparam int IDX_W = VPN_W / PTW_LEVELS
) (
    input  logic [VPN_W-1:0] vpn,
    input  level_t           level,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] fields [PTW_LEVELS];

    for (genvar g = 0; g < PTW_LEVELS; g++) begin : g_field
        // level 0 takes the most significant slice
        assign fields[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
    end

    assign idx = fields[level];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] entry_addr
);

    logic [ADDR_W-1:0] aligned_base;
    logic [ADDR_W-1:0] byte_offset;
    logic              unused_low;

    assign aligned_base = {table_base[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    assign byte_offset  = ADDR_W'({idx, {PTE_SIZE_LOG2{1'b0}}});
    assign entry_addr   = aligned_base + byte_offset;
    assign unused_low   = ^table_base[PAGE_SHIFT-1:0];

endmodule

// File: rtl/ptw_pte_chk.sv
module ptw_pte_chk
    import ptw_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 40
) (
    input  logic [PTE_W-1:0]  pte,
    output logic              present,
    output logic [ADDR_W-1:0] next_base
);

    logic unused_bits;

    assign present     = pte[PTE_PRESENT_BIT];
    assign next_base   = {pte[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    assign unused_bits = ^{pte[PTE_W-1:ADDR_W], pte[PAGE_SHIFT-1:1]};

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int VPN_W  = 27,
    parameter int ADDR_W = 40,
    parameter int PTE_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ADDR_W-1:0] miss_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    input  logic              rsp_present,
    input  logic [ADDR_W-1:0] rsp_next_base,
    output logic [VPN_W-1:0]  cur_vpn,
    output logic [ADDR_W-1:0] cur_base,
    output level_t            cur_level,
    output logic              done_valid,
    output logic [PTE_W-1:0]  done_pte,
    output logic              fault_valid
);

    walk_state_e       state;
    level_t            level;
    logic [VPN_W-1:0]  vpn_q;
    logic [ADDR_W-1:0] base_q;
    logic [PTE_W-1:0]  pte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            level  <= '0;
            vpn_q  <= '0;
            base_q <= '0;
            pte_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (miss_valid) begin
                        vpn_q  <= miss_vpn;
                        base_q <= miss_root;
                        level  <= '0;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (mem_rsp_valid) begin
                        pte_q <= mem_rsp_data;
                        if (!rsp_present) begin
                            state <= ST_FAULT;
                        end else if (level == last_level()) begin
                            state <= ST_INSTALL;
                        end else begin
                            level  <= level + 2'd1;
                            base_q <= rsp_next_base;
                            state  <= ST_ISSUE;
                        end
                    end
                end
                ST_INSTALL: state <= ST_IDLE;
                ST_FAULT:   state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign miss_ready    = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign done_valid    = (state == ST_INSTALL);
    assign fault_valid   = (state == ST_FAULT);
    assign done_pte      = pte_q;
    assign cur_vpn       = vpn_q;
    assign cur_base      = base_q;
    assign cur_level     = level;

    // reads issued in the current walk, kept for the checks below
    logic [1:0] rd_cnt;
    always_ff @(posedge clk) begin
        if (rst || miss_ready) rd_cnt <= '0;
        else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 2'd1;
    end

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        miss_valid && miss_ready |=> !miss_ready);

    p_single_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    p_install_present_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> done_pte[PTE_PRESENT_BIT]);

    p_three_reads_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> rd_cnt == 2'd3);

    p_fault_stops_r8: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !mem_req_valid);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done_valid || fault_valid |=> miss_ready);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import ptw_pkg::*;
#(
    parameter int VPN_W  = 27,
    parameter int ADDR_W = 40,
    parameter int PTE_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ADDR_W-1:0] miss_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic [PTE_W-1:0]  done_pte,
    output logic              fault_valid,
    output logic [1:0]        fault_level,
    output logic [VPN_W-1:0]  result_vpn
);

    localparam int IDX_W = VPN_W / PTW_LEVELS;

    logic              rsp_present;
    logic [ADDR_W-1:0] rsp_next_base;
    logic [VPN_W-1:0]  cur_vpn;
    logic [ADDR_W-1:0] cur_base;
    level_t            cur_level;
    logic [IDX_W-1:0]  cur_idx;

    ptw_ctrl #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .PTE_W(PTE_W)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .miss_ready    (miss_ready),
        .miss_vpn      (miss_vpn),
        .miss_root     (miss_root),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_present   (rsp_present),
        .rsp_next_base (rsp_next_base),
        .cur_vpn       (cur_vpn),
        .cur_base      (cur_base),
        .cur_level     (cur_level),
        .done_valid    (done_valid),
        .done_pte      (done_pte),
        .fault_valid   (fault_valid)
    );

    ptw_index_sel #(.VPN_W(VPN_W)) idx_i (
        .vpn   (cur_vpn),
        .level (cur_level),
        .idx   (cur_idx)
    );

    ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
        .table_base (cur_base),
        .idx        (cur_idx),
        .entry_addr (mem_req_addr)
    );

    ptw_pte_chk #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) chk_i (
        .pte       (mem_rsp_data),
        .present   (rsp_present),
        .next_base (rsp_next_base)
    );

    assign fault_level = cur_level;
    assign result_vpn  = cur_vpn;

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !done_valid);

endmodule

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [26:0] miss_vpn = '0;
    logic [39:0] miss_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [63:0] done_pte;
    logic        fault_valid;
    logic [1:0]  fault_level;
    logic [26:0] result_vpn;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vpn(miss_vpn), .miss_root(miss_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_pte(done_pte),
        .fault_valid(fault_valid), .fault_level(fault_level),
        .result_vpn(result_vpn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] exp_addr(input logic [39:0] base,
                                             input logic [26:0] vpn, input int l);
        logic [26:0] sh;
        sh = vpn >> (9 * (2 - l));
        return {base[39:12], 12'h000} + {28'h0, sh[8:0], 3'b000};
    endfunction

    function automatic logic [63:0] mem_word(input logic [39:0] a, input int l, input bit p);
        logic [39:0] mix;
        mix = a[39:3] * 40'd3 + 40'(l * 5 + 1);
        return {24'h0, mix[27:0], 11'h0, p};
    endfunction

    function automatic logic [26:0] vpn_pat(input int i);
        case (i)
            0: return 27'h0;
            1: return 27'h7FFFFFF;
            2: return {9'h1FF, 18'h0};
            3: return {9'h0, 9'h1FF, 9'h0};
            4: return {18'h0, 9'h1FF};
            5: return 27'h2D2D2D5;
            6: return 27'h1234567;
            default: return {9'h101, 9'h0AA, 9'h155};
        endcase
    endfunction

    // flt: level (0..2) whose entry is not present, 3 for a full install
    task automatic walk(input logic [26:0] vpn, input logic [39:0] root,
                        input int flt, input int adly, input int rdly);
        logic [39:0] base;
        logic [39:0] ea;
        logic [63:0] w;
        bit ended;
        base  = root;
        ended = 0;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R2", "ready before walk", 64'(miss_ready), 64'h1);
        miss_valid = 1'b1; miss_vpn = vpn; miss_root = root;
        @(posedge clk); @(negedge clk);
        miss_valid = 1'b0;
        chk(miss_ready == 1'b0, "R2", "busy after accept", 64'(miss_ready), 64'h0);
        for (int l = 0; l < 3; l++) begin
            if (ended) break;
            ea = exp_addr(base, vpn, l);
            chk(mem_req_valid == 1'b1, l == 0 ? "R3" : "R4", "request raised",
                64'(mem_req_valid), 64'h1);
            chk(mem_req_addr == ea, l == 0 ? "R3" : "R4", "read address",
                64'(mem_req_addr), 64'(ea));
            for (int d = 0; d < adly; d++) begin
                @(posedge clk); @(negedge clk);
                chk(mem_req_valid == 1'b1 && mem_req_addr == ea, "R5", "held request",
                    64'(mem_req_addr), 64'(ea));
            end
            mem_req_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R6", "no request while waiting",
                64'(mem_req_valid), 64'h0);
            // a second miss while busy must be ignored
            miss_valid = 1'b1; miss_vpn = ~vpn; miss_root = ~root;
            for (int d = 0; d < rdly; d++) begin
                @(posedge clk); @(negedge clk);
                chk(mem_req_valid == 1'b0, "R6", "still one outstanding",
                    64'(mem_req_valid), 64'h0);
                chk(miss_ready == 1'b0, "R2", "ready low while busy",
                    64'(miss_ready), 64'h0);
            end
            miss_valid = 1'b0;
            w = mem_word(ea, l, flt != l);
            mem_rsp_valid = 1'b1; mem_rsp_data = w;
            @(posedge clk); @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (flt == l) begin
                chk(fault_valid == 1'b1, "R8", "fault raised", 64'(fault_valid), 64'h1);
                chk(fault_level == 2'(l), "R8", "fault level", 64'(fault_level), 64'(l));
                chk(result_vpn == vpn, "R2", "fault vpn kept", 64'(result_vpn), 64'(vpn));
                chk(done_valid == 1'b0 && mem_req_valid == 1'b0, "R8", "no install, no read",
                    64'({done_valid, mem_req_valid}), 64'h0);
                ended = 1;
            end else if (l == 2) begin
                chk(done_valid == 1'b1, "R7", "install raised", 64'(done_valid), 64'h1);
                chk(done_pte == w, "R7", "installed entry", done_pte, w);
                chk(result_vpn == vpn, "R7", "installed vpn", 64'(result_vpn), 64'(vpn));
                chk(fault_valid == 1'b0, "R7", "no fault", 64'(fault_valid), 64'h0);
                ended = 1;
            end
            base = {w[39:12], 12'h000};
        end
        @(posedge clk); @(negedge clk);
        chk(done_valid == 1'b0 && fault_valid == 1'b0, flt == 3 ? "R7" : "R8",
            "single-cycle outcome", 64'({done_valid, fault_valid}), 64'h0);
        chk(miss_ready == 1'b1, "R9", "idle after outcome", 64'(miss_ready), 64'h1);
        chk(mem_req_valid == 1'b0, "R8", "no read after end", 64'(mem_req_valid), 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(miss_ready == 1'b1, "R1", "reset ready", 64'(miss_ready), 64'h1);
        chk(mem_req_valid == 1'b0, "R1", "reset request", 64'(mem_req_valid), 64'h0);
        chk(done_valid == 1'b0 && fault_valid == 1'b0, "R1", "reset outcome",
            64'({done_valid, fault_valid}), 64'h0);
        for (int i = 0; i < 8; i++) begin
            for (int f = 0; f < 4; f++) begin
                walk(vpn_pat(i), 40'h00_1234_5000 + 40'(i * 'h3000 + f * 'h1000) + 40'hABC,
                     f, (i + f) % 3, (i * f) % 4);
            end
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule